// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns parallel words into an asynchronous serial character stream on a single output line. A sample tick, supplied from outside at sixteen ticks per bit period, paces every bit. Words arrive over a valid/ready handshake. The line idles high. Each character is a low start bit, then 5 to 9 data bits in the chosen order, then an optional parity-position bit, then a high stop interval of one, one and a half or two bit periods.

Static configuration inputs choose the character shape. A programmable timeguard keeps the line idle for a number of whole bit periods after each character, which gives a slow receiver time to recover. A break request drives the line low for a whole character time and then high for one bit period. In multidrop mode, the parity-position bit marks a character as an address or as data.

Top module: `sertx_core`

## Requirements
- R1: After reset, and whenever no character, timeguard or break is in progress, `tx` is 1 and `in_ready` equals the inverse of `brk_req`.
- R2: A word is accepted on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `tx` is 0 for 16 ticks (the start bit). Every data bit that follows lasts 16 ticks.
- R3: `cfg_len` sets the number of data bits. Values 5 to 9 are used as given, values below 5 act as 5 and values above 9 act as 9. Bits of `in_data` at or above that count never reach the line.
- R4: With `cfg_msb` = 0, data bits go out least significant first. With `cfg_msb` = 1, the highest used bit goes first.
- R5: `cfg_par` codes: 0 = no parity bit, 1 = even (the bit makes the count of ones over data and parity even), 2 = odd, 3 = constant 0, 4 = constant 1, 5 to 7 = no parity bit. The parity bit lasts 16 ticks.
- R6: With `cfg_md` = 1, a parity-position bit is always sent, equal to `in_addr` (1 = address, 0 = data), whatever `cfg_par` is.
- R7: `cfg_stop` codes: 0 = 16 ticks high, 1 = 24 ticks high, 2 or 3 = 32 ticks high.
- R8: After the stop interval, the line stays high for 16 × `cfg_tg` further ticks, and only then does `in_ready` return. With `cfg_tg` = 0 there is no gap.
- R9: An accepted break drives `tx` low from the next cycle for 16 × (1 + data bits + parity-position bit) + stop ticks, then high for 16 ticks. After that the block is idle.
- R10: A break is accepted when the block is idle and `brk_req` = 1, and it wins over a pending word: `in_ready` is 0 while `brk_req` is 1.
- R11: `brk_req` has no effect while a character is in progress. The character completes unchanged and the block returns to idle.
- R12: `in_ready` stays 0 from acceptance until the character, including its timeguard, has ended. `tx` changes only on a tick cycle or on the cycle after an acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sample tick, 16 per bit period |
| cfg_len | input | 4 | Data bit count (5 to 9, clamped) |
| cfg_par | input | 3 | Parity mode code |
| cfg_stop | input | 2 | Stop interval code |
| cfg_msb | input | 1 | 1 = most significant data bit first |
| cfg_md | input | 1 | Multidrop mode enable |
| cfg_tg | input | 8 | Timeguard length in bit periods |
| in_valid | input | 1 | Word offered |
| in_ready | output | 1 | Word can be taken |
| in_data | input | 9 | Word to send |
| in_addr | input | 1 | Multidrop address marker for the word |
| brk_req | input | 1 | Break request |
| tx | output | 1 | Serial line |

## Verification
The bench sweeps every combination of data bit count, parity mode, stop interval and bit order. It compares the line level on each tick with a waveform worked out arithmetically, so a stop interval that is off by half a bit, a reversed bit order or an inverted parity sense shows up on the exact tick where the waveform diverges. Words with bits set above the chosen length catch masking errors: an unmasked design would send a wrong parity bit or wrong data bits. Clamped length codes, multidrop address and data markers, and nonzero timeguards are also covered. A timeguard that is counted wrongly or skipped would release `in_ready` early. Breaks are tested in two shapes, together with a break raised at the same moment as a word (a design that let the word win would send a start bit followed by data) and a break request held through a character (a design that obeyed it would cut the frame short or start a break afterwards).

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP,
        ST_GUARD,
        ST_BRK,
        ST_BRKH
    } sertx_st_e;

    localparam logic [2:0] PAR_NONE = 3'd0;
    localparam logic [2:0] PAR_EVEN = 3'd1;
    localparam logic [2:0] PAR_ODD  = 3'd2;
    localparam logic [2:0] PAR_ZERO = 3'd3;
    localparam logic [2:0] PAR_ONE  = 3'd4;

    // Clamp a requested data bit count into [lo, hi]
    function automatic logic [3:0] clamp_len(input logic [3:0] req,
                                             input logic [3:0] lo,
                                             input logic [3:0] hi);
        if (req < lo)      return lo;
        else if (req > hi) return hi;
        else               return req;
    endfunction

endpackage

// File: rtl/sertx_parity.sv
module sertx_parity #(
    parameter int DW = 9
) (
    input  logic [DW-1:0] data,
    input  logic [3:0]    nbits,
    input  logic [2:0]    mode,
    input  logic          md,
    input  logic          addr,
    output logic          par_en,
    output logic          par_bit
);
    import sertx_pkg::*;

    logic ones;

    always_comb begin
        ones = 1'b0;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(nbits)) ones = ones ^ data[i];
        end
        if (md) begin
            par_en  = 1'b1;
            par_bit = addr;
        end else begin
            unique case (mode)
                PAR_EVEN: begin par_en = 1'b1; par_bit = ones;  end
                PAR_ODD:  begin par_en = 1'b1; par_bit = ~ones; end
                PAR_ZERO: begin par_en = 1'b1; par_bit = 1'b0;  end
                PAR_ONE:  begin par_en = 1'b1; par_bit = 1'b1;  end
                default:  begin par_en = 1'b0; par_bit = 1'b0;  end
            endcase
        end
    end

endmodule

// File: rtl/sertx_order.sv
module sertx_order #(
    parameter int DW = 9
) (
    input  logic [DW-1:0] data,
    input  logic [3:0]    nbits,
    input  logic          msb_first,
    output logic [DW-1:0] word
);
    // word[0] is the first data bit on the line; unused bits are zero
    always_comb begin
        word = '0;
        for (int i = 0; i < DW; i++) begin
            if (i < int'(nbits)) begin
                if (msb_first) word[i] = data[int'(nbits) - 1 - i];
                else           word[i] = data[i];
            end
        end
    end

endmodule

// File: rtl/sertx_core.sv
module sertx_core #(
    parameter int SPB     = 16,
    parameter int DW      = 9,
    parameter int MIN_LEN = 5,
    parameter int TG_W    = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [3:0]    cfg_len,
    input  logic [2:0]    cfg_par,
    input  logic [1:0]    cfg_stop,
    input  logic          cfg_msb,
    input  logic          cfg_md,
    input  logic [TG_W-1:0] cfg_tg,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_data,
    input  logic          in_addr,
    input  logic          brk_req,
    output logic          tx
);
    import sertx_pkg::*;

    localparam int CNT_W = $clog2(SPB * (2 ** TG_W)) + 1;
    localparam logic [CNT_W-1:0] BIT_T  = CNT_W'(SPB);
    localparam logic [CNT_W-1:0] HALF_T = CNT_W'(SPB / 2);

    typedef struct packed {
        sertx_st_e       st;
        logic [CNT_W-1:0] left;
        logic [3:0]      bitn;
        logic [DW-1:0]   sh;
        logic            par;
        logic            tx;
    } sertx_reg_t;

    sertx_reg_t r_q, r_d;

    logic [3:0]       nbits;
    logic             par_en, par_bit;
    logic [DW-1:0]    ordered;
    logic [CNT_W-1:0] stop_t, brk_t, guard_t;
    logic             seg_end;

    assign nbits = clamp_len(cfg_len, 4'(MIN_LEN), 4'(DW));

    sertx_parity #(.DW(DW)) u_par (
        .data    (in_data),
        .nbits   (nbits),
        .mode    (cfg_par),
        .md      (cfg_md),
        .addr    (in_addr),
        .par_en  (par_en),
        .par_bit (par_bit)
    );

    sertx_order #(.DW(DW)) u_ord (
        .data      (in_data),
        .nbits     (nbits),
        .msb_first (cfg_msb),
        .word      (ordered)
    );

    always_comb begin
        unique case (cfg_stop)
            2'd0:    stop_t = BIT_T;
            2'd1:    stop_t = BIT_T + HALF_T;
            default: stop_t = BIT_T + BIT_T;
        endcase
        brk_t   = BIT_T * (CNT_W'(1) + CNT_W'(nbits) + CNT_W'(par_en)) + stop_t;
        guard_t = BIT_T * CNT_W'(cfg_tg);
    end

    assign in_ready = (r_q.st == ST_IDLE) && !brk_req;
    assign tx       = r_q.tx;
    assign seg_end  = tick && (r_q.left == CNT_W'(1));

    always_comb begin
        r_d = r_q;
        if (tick && r_q.st != ST_IDLE) r_d.left = r_q.left - CNT_W'(1);
        unique case (r_q.st)
            ST_IDLE: begin
                if (brk_req) begin
                    r_d.st   = ST_BRK;
                    r_d.left = brk_t;
                    r_d.tx   = 1'b0;
                end else if (in_valid) begin
                    r_d.st   = ST_START;
                    r_d.left = BIT_T;
                    r_d.tx   = 1'b0;
                    r_d.sh   = ordered;
                    r_d.par  = par_bit;
                end
            end
            ST_START: if (seg_end) begin
                r_d.st   = ST_DATA;
                r_d.left = BIT_T;
                r_d.tx   = r_q.sh[0];
                r_d.sh   = r_q.sh >> 1;
                r_d.bitn = nbits - 4'd1;
            end
            ST_DATA: if (seg_end) begin
                r_d.left = BIT_T;
                if (r_q.bitn != 4'd0) begin
                    r_d.tx   = r_q.sh[0];
                    r_d.sh   = r_q.sh >> 1;
                    r_d.bitn = r_q.bitn - 4'd1;
                end else if (par_en) begin
                    r_d.st = ST_PAR;
                    r_d.tx = r_q.par;
                end else begin
                    r_d.st   = ST_STOP;
                    r_d.left = stop_t;
                    r_d.tx   = 1'b1;
                end
            end
            ST_PAR: if (seg_end) begin
                r_d.st   = ST_STOP;
                r_d.left = stop_t;
                r_d.tx   = 1'b1;
            end
            ST_STOP: if (seg_end) begin
                if (cfg_tg != '0) begin
                    r_d.st   = ST_GUARD;
                    r_d.left = guard_t;
                end else begin
                    r_d.st = ST_IDLE;
                end
            end
            ST_GUARD: if (seg_end) r_d.st = ST_IDLE;
            ST_BRK: if (seg_end) begin
                r_d.st   = ST_BRKH;
                r_d.left = BIT_T;
                r_d.tx   = 1'b1;
            end
            ST_BRKH: if (seg_end) r_d.st = ST_IDLE;
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.tx   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    // R1: line is high whenever idle
    p_idle_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> tx);

    // R2: acceptance of a word starts a low start bit
    p_start_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (!tx && r_q.st == ST_START));

    // R7: stop interval and timeguard keep the line high
    p_stop_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_STOP || r_q.st == ST_GUARD) |-> tx);

    // R9: accepted break drives the line low next cycle
    p_brk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE && brk_req) |=> (!tx && r_q.st == ST_BRK));

    // R10: a pending break blocks word acceptance
    p_brk_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        brk_req |-> !in_ready);

    // R12: ready drops after acceptance; line moves only on tick or start
    p_ready_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    p_tx_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !(r_q.st == ST_IDLE && (brk_req || in_valid))) |=> $stable(tx));

endmodule

// File: tb/sertx_core_tb.sv
module sertx_core_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick;
    logic [3:0] cfg_len = 4'd8;
    logic [2:0] cfg_par = 3'd0;
    logic [1:0] cfg_stop = 2'd0;
    logic       cfg_msb = 1'b0;
    logic       cfg_md = 1'b0;
    logic [7:0] cfg_tg = 8'd0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [8:0] in_data = '0;
    logic       in_addr = 1'b0;
    logic       brk_req = 1'b0;
    logic       tx;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic exp_s [0:1023];
    int   exp_n;

    always #2 clk = ~clk;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) tick <= 1'b0;
        else        tick <= ~tick;
    end

    sertx_core u_dut (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cfg_len(cfg_len), .cfg_par(cfg_par), .cfg_stop(cfg_stop),
        .cfg_msb(cfg_msb), .cfg_md(cfg_md), .cfg_tg(cfg_tg),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .in_addr(in_addr), .brk_req(brk_req), .tx(tx)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int eff_len(input int l);
        if (l < 5) return 5;
        if (l > 9) return 9;
        return l;
    endfunction

    function automatic int stop_ticks(input int s);
        if (s == 0) return 16;
        if (s == 1) return 24;
        return 32;
    endfunction

    function automatic int has_par();
        return (cfg_md || (cfg_par >= 3'd1 && cfg_par <= 3'd4)) ? 1 : 0;
    endfunction

    task automatic push(input logic v, input int n);
        for (int k = 0; k < n; k++) begin
            exp_s[exp_n] = v;
            exp_n++;
        end
    endtask

    task automatic build_char(input logic [8:0] d, input logic a);
        int  n;
        logic ones;
        logic pb;
        n = eff_len(int'(cfg_len));
        exp_n = 0;
        ones = 1'b0;
        for (int k = 0; k < n; k++) ones ^= d[k];
        push(1'b0, 16);
        for (int k = 0; k < n; k++) push(cfg_msb ? d[n-1-k] : d[k], 16);
        if (has_par() == 1) begin
            if (cfg_md)               pb = a;
            else if (cfg_par == 3'd1) pb = ones;
            else if (cfg_par == 3'd2) pb = ~ones;
            else if (cfg_par == 3'd3) pb = 1'b0;
            else                      pb = 1'b1;
            push(pb, 16);
        end
        push(1'b1, stop_ticks(int'(cfg_stop)));
        push(1'b1, 16 * int'(cfg_tg));
    endtask

    task automatic build_brk();
        exp_n = 0;
        push(1'b0, 16 * (1 + eff_len(int'(cfg_len)) + has_par()) + stop_ticks(int'(cfg_stop)));
        push(1'b1, 16);
    endtask

    // Called right after the posedge where the word or break was taken
    task automatic run_expect(input string tag, input bit brk_during);
        int  i;
        bit  bad;
        int  bad_i;
        int  bad_v;
        i = 0;
        bad = 1'b0;
        bad_i = 0;
        bad_v = 0;
        while (i < exp_n) begin
            @(negedge clk);
            in_valid = 1'b0;
            brk_req  = brk_during && (i > 0) && (i < exp_n - 1);
            if (tick) begin
                if (!bad && (tx !== exp_s[i] || in_ready !== 1'b0)) begin
                    bad = 1'b1;
                    bad_i = i;
                    bad_v = int'(tx);
                end
                i++;
            end
        end
        check(!bad, $sformatf("%s waveform at tick %0d", tag, bad_i), bad_v,
              bad ? int'(exp_s[bad_i]) : bad_v);
        @(negedge clk);
        brk_req = 1'b0;
        check(in_ready === 1'b1 && tx === 1'b1, {tag, " idle after frame"},
              int'({in_ready, tx}), 3);
    endtask

    task automatic send(input logic [8:0] d, input logic a, input string tag,
                        input bit brk_during);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        in_addr  = a;
        build_char(d, a);
        @(posedge clk);
        run_expect(tag, brk_during);
    endtask

    task automatic send_brk(input string tag);
        @(negedge clk);
        brk_req = 1'b1;
        build_brk();
        @(posedge clk);
        run_expect(tag, 1'b0);
    endtask

    initial begin
        int seed;
        seed = 5;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(tx === 1'b1 && in_ready === 1'b1, "R1 reset state", int'({in_ready, tx}), 3);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(tx === 1'b1 && in_ready === 1'b1, "R1 idle after reset", int'({in_ready, tx}), 3);

        // R2 R3 R4 R5 R7 R12: full sweep of shape settings
        for (int l = 5; l <= 9; l++)
            for (int p = 0; p <= 4; p++)
                for (int s = 0; s <= 2; s++)
                    for (int m = 0; m <= 1; m++) begin
                        cfg_len  = 4'(l);
                        cfg_par  = 3'(p);
                        cfg_stop = 2'(s);
                        cfg_msb  = m[0];
                        seed = (seed * 37 + 101) % 512;
                        send(9'(seed), 1'b0, "R2_R4_R5_R7 sweep", 1'b0);
                    end

        // R5: unused parity codes act as none; R7: code 3 acts as two stops
        cfg_len = 4'd7; cfg_stop = 2'd3;
        for (int p = 5; p <= 7; p++) begin
            cfg_par = 3'(p);
            send(9'h1A5, 1'b0, "R5 spare parity code", 1'b0);
        end

        // R3: clamped length codes, high bits set above length
        cfg_par = 3'd1; cfg_stop = 2'd0;
        cfg_len = 4'd2;  send(9'h1EA, 1'b0, "R3 length below range", 1'b0);
        cfg_len = 4'd15; send(9'h155, 1'b0, "R3 length above range", 1'b0);
        cfg_len = 4'd0;  cfg_msb = 1'b1; send(9'h1F3, 1'b0, "R3 R4 clamp msb", 1'b0);
        cfg_msb = 1'b0;

        // R6: multidrop address and data markers override parity mode
        cfg_md = 1'b1;
        for (int l = 5; l <= 9; l++)
            for (int a = 0; a <= 1; a++) begin
                cfg_len = 4'(l);
                cfg_par = 3'(a * 3);
                send(9'h0F0 ^ 9'(l), a[0], "R6 multidrop marker", 1'b0);
            end
        cfg_md = 1'b0;

        // R8: timeguard
        cfg_len = 4'd8; cfg_par = 3'd0; cfg_stop = 2'd1;
        for (int g = 1; g <= 3; g++) begin
            cfg_tg = 8'(g);
            send(9'h03C, 1'b0, "R8 timeguard", 1'b0);
        end
        cfg_tg = 8'd0;

        // R9: break in two shapes
        cfg_len = 4'd8; cfg_par = 3'd0; cfg_stop = 2'd0;
        send_brk("R9 break 8N1");
        cfg_len = 4'd9; cfg_par = 3'd2; cfg_stop = 2'd1;
        send_brk("R9 break 9O1.5");

        // R10: break and word raised together, break wins
        cfg_len = 4'd8; cfg_par = 3'd0; cfg_stop = 2'd0;
        @(negedge clk);
        check(in_ready === 1'b1, "R10 ready before request", int'(in_ready), 1);
        brk_req  = 1'b1;
        in_valid = 1'b1;
        in_data  = 9'h0FF;
        #0;
        check(in_ready === 1'b0, "R10 ready low under break request", int'(in_ready), 0);
        build_brk();
        @(posedge clk);
        run_expect("R10 break over word", 1'b0);
        send(9'h0FF, 1'b0, "R10 word after break", 1'b0);

        // R11: break request during a character is ignored
        cfg_par = 3'd1; cfg_tg = 8'd1;
        send(9'h0A7, 1'b0, "R11 break ignored while busy", 1'b1);
        cfg_tg = 8'd0;
        repeat (40) @(negedge clk);
        check(tx === 1'b1 && in_ready === 1'b1, "R11 no late break", int'({in_ready, tx}), 3);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule